// File: doc/BRIEF.md
# LPC Locality-Cycle Target Decoder

This block sits on the peripheral side of a Low Pin Count bus and runs on the bus clock. It follows the framing strobe and the 4-bit address/data lines, picks out only the locality-addressed trusted-module read and write cycles, and turns each into one request toward a register file. The 16-bit cycle address is split into a locality number and a 12-bit register offset. Every other cycle type passes by without the block ever driving the bus.

The register side answers a request with a ready/grant pair. While it holds back, the block stretches the bus cycle with long-wait SYNC nibbles. A granted access ends with a SYNC OK nibble and, for reads, one data byte. A refused access gets no SYNC at all, so the host master-aborts it. An error SYNC is never produced. The request is a valid/ready handshake. `req_valid` stays high with stable fields until the register side raises `req_ready`. `req_grant` and `req_rdata` are sampled in that same clock. The register side must commit a write only when it grants it. A refusal should be given in the first request clock, because a refusal that comes after long-wait nibbles leaves the host to time out.

Top module: `lpc_tpm_target`

## Requirements
- R1: A cycle is decoded when `frame_n` is low with start nibble 0101, followed by cycle-type nibble 0000 (read) or 0010 (write) and four address nibbles, most significant first. `req_locality` is address bits 15:12 and `req_offset` is address bits 11:0.
- R2: A start nibble other than 0101, or a cycle-type nibble other than 0000/0010, is ignored. LAD stays undriven and no request is raised.
- R3: A cycle whose locality field (address bits 15:12) is 5 to 15 is ignored. LAD stays undriven and no request is raised.
- R4: A write carries two data nibbles, low nibble first, and they appear as `req_wdata` with `req_write` high. Counting the start clock as clock 1, `req_valid` rises in clock 9 for a read and in clock 11 for a write, after two host turnaround clocks.
- R5: `req_valid` stays high, and write, locality, offset and write data stay unchanged, until `req_ready` is high.
- R6: In the first request clock LAD is undriven. In every later request clock, until the handshake, LAD carries the long-wait nibble 0110.
- R7: In the clock after a handshake with `req_grant` high, LAD carries SYNC OK 0000.
- R8: After a handshake with `req_grant` low, LAD is undriven from the next clock on, and no request is raised again until a new start.
- R9: After SYNC OK, a read drives `req_rdata` low nibble then high nibble over two clocks and then releases LAD for two turnaround clocks. A write releases LAD right after SYNC OK.
- R10: `frame_n` low in any clock restarts decoding from that clock's nibble. `req_valid` is low in that clock, and LAD is undriven in the next one.
- R11: After reset LAD is undriven and `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Cycle framing strobe, active low |
| lad_in | input | 4 | Nibble seen on the address/data lines |
| lad_out | output | 4 | Nibble the block drives |
| lad_oe | output | 1 | Output enable for `lad_out` |
| req_valid | output | 1 | Register request pending |
| req_ready | input | 1 | Register side answers this clock |
| req_write | output | 1 | 1 = write, 0 = read |
| req_locality | output | 3 | Locality 0 to 4 |
| req_offset | output | 12 | Register offset inside the locality |
| req_wdata | output | 8 | Write byte |
| req_grant | input | 1 | With `req_ready`: 1 accept, 0 refuse |
| req_rdata | input | 8 | Read byte, sampled at the accepted handshake |

## Verification
Reads and writes are run against a register side that answers at once, and against one that stalls for several clocks. Together they separate the silent first request clock, the run of long-wait nibbles and the position of SYNC OK. Refused reads and writes, both immediate and after stalls, show that the block releases LAD instead of signalling. Plain I/O and memory cycles and out-of-range localities show that foreign traffic is never answered. A framing strobe is also raised mid-address, mid-data and mid-wait, to show where decoding restarts and that the next cycle runs normally.

// File: rtl/lpc_tpm_pkg.sv
package lpc_tpm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_ADDR, ST_WDATA, ST_HTAR,
    ST_REQ, ST_SYNC, ST_RDATA, ST_TTAR
  } lpc_state_e;

  localparam logic [3:0] NIB_START = 4'b0101;
  localparam logic [3:0] NIB_RD    = 4'b0000;
  localparam logic [3:0] NIB_WR    = 4'b0010;
  localparam logic [3:0] NIB_OK    = 4'b0000;
  localparam logic [3:0] NIB_LWAIT = 4'b0110;
  localparam int         TAR_CLKS  = 2;
endpackage

// File: rtl/lpc_tpm_capture.sv
module lpc_tpm_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        lad_in,
  input  logic              addr_shift,
  input  logic              data_shift,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  // address arrives high nibble first, data low nibble first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (addr_shift) addr_q  <= {addr_q[ADDR_W-5:0], lad_in};
      if (data_shift) wdata_q <= {lad_in, wdata_q[DATA_W-1:4]};
    end
  end
endmodule

// File: rtl/lpc_tpm_seq.sv
module lpc_tpm_seq
  import lpc_tpm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [3:0] lad_in,
  input  logic       loc_ok,
  input  logic       req_ready,
  input  logic       req_grant,
  output lpc_state_e state_q,
  output logic       waited_q,
  output logic       is_wr_q,
  output logic       addr_shift,
  output logic       data_shift,
  output logic       take_rdata,
  output logic       rd_shift
);
  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int DATA_NIB = DATA_W / 4;
  localparam int CNT_W    = $clog2(ADDR_NIB + 1);

  lpc_state_e       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_wr_d, waited_d;
  logic             last_addr, last_data, last_tar;

  assign last_addr = (cnt_q == CNT_W'(ADDR_NIB - 1));
  assign last_data = (cnt_q == CNT_W'(DATA_NIB - 1));
  assign last_tar  = (cnt_q == CNT_W'(TAR_CLKS - 1));

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q + 1'b1;
    is_wr_d  = is_wr_q;
    waited_d = waited_q;
    if (!frame_n) begin
      // framing strobe overrides every state
      state_d = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: cnt_d = '0;
        ST_CTYPE: begin
          cnt_d = '0;
          if (lad_in == NIB_RD) begin
            is_wr_d = 1'b0;
            state_d = ST_ADDR;
          end else if (lad_in == NIB_WR) begin
            is_wr_d = 1'b1;
            state_d = ST_ADDR;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_ADDR: if (last_addr) begin
          cnt_d   = '0;
          state_d = is_wr_q ? ST_WDATA : ST_HTAR;
        end
        ST_WDATA: if (last_data) begin
          cnt_d   = '0;
          state_d = ST_HTAR;
        end
        ST_HTAR: if (last_tar) begin
          cnt_d    = '0;
          waited_d = 1'b0;
          state_d  = loc_ok ? ST_REQ : ST_IDLE;
        end
        ST_REQ: begin
          cnt_d    = '0;
          waited_d = 1'b1;
          if (req_ready) state_d = req_grant ? ST_SYNC : ST_IDLE;
        end
        ST_SYNC: begin
          cnt_d   = '0;
          state_d = is_wr_q ? ST_TTAR : ST_RDATA;
        end
        ST_RDATA: if (last_data) begin
          cnt_d   = '0;
          state_d = ST_TTAR;
        end
        ST_TTAR: if (last_tar) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end
        default: begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      is_wr_q  <= 1'b0;
      waited_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      is_wr_q  <= is_wr_d;
      waited_q <= waited_d;
    end
  end

  assign addr_shift = frame_n && (state_q == ST_ADDR);
  assign data_shift = frame_n && (state_q == ST_WDATA);
  assign take_rdata = frame_n && (state_q == ST_REQ) && req_ready && req_grant;
  assign rd_shift   = (state_q == ST_RDATA);
endmodule

// File: rtl/lpc_tpm_drive.sv
module lpc_tpm_drive
  import lpc_tpm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lpc_state_e        state_q,
  input  logic              waited_q,
  input  logic              take_rdata,
  input  logic              rd_shift,
  input  logic [DATA_W-1:0] req_rdata,
  output logic [3:0]        lad_out,
  output logic              lad_oe
);
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_q <= '0;
    else if (take_rdata) rd_q <= req_rdata;
    else if (rd_shift)   rd_q <= {4'b0000, rd_q[DATA_W-1:4]};
  end

  // output depends on registered state only
  always_comb begin
    lad_oe  = 1'b0;
    lad_out = 4'b0000;
    unique case (state_q)
      ST_REQ: begin
        lad_oe  = waited_q;
        lad_out = NIB_LWAIT;
      end
      ST_SYNC: begin
        lad_oe  = 1'b1;
        lad_out = NIB_OK;
      end
      ST_RDATA: begin
        lad_oe  = 1'b1;
        lad_out = rd_q[3:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpc_tpm_target.sv
module lpc_tpm_target
  import lpc_tpm_pkg::*;
#(
  parameter int   ADDR_W  = 16,
  parameter int   DATA_W  = 8,
  parameter int   LOC_W   = 4,
  parameter int   NUM_LOC = 5,
  localparam int  OFS_W   = ADDR_W - LOC_W,
  localparam int  LSEL_W  = $clog2(NUM_LOC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [LSEL_W-1:0] req_locality,
  output logic [OFS_W-1:0]  req_offset,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_grant,
  input  logic [DATA_W-1:0] req_rdata
);
  lpc_state_e        state_q;
  logic              waited_q, is_wr_q;
  logic              addr_shift, data_shift, take_rdata, rd_shift;
  logic [ADDR_W-1:0] addr_q;
  logic [LOC_W-1:0]  loc_field;
  logic              loc_ok;

  assign loc_field = addr_q[ADDR_W-1 -: LOC_W];
  assign loc_ok    = (loc_field < LOC_W'(NUM_LOC));

  lpc_tpm_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .lad_in(lad_in),
    .addr_shift(addr_shift), .data_shift(data_shift),
    .addr_q(addr_q), .wdata_q(req_wdata)
  );

  lpc_tpm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .loc_ok(loc_ok), .req_ready(req_ready), .req_grant(req_grant),
    .state_q(state_q), .waited_q(waited_q), .is_wr_q(is_wr_q),
    .addr_shift(addr_shift), .data_shift(data_shift),
    .take_rdata(take_rdata), .rd_shift(rd_shift)
  );

  lpc_tpm_drive #(.DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .waited_q(waited_q),
    .take_rdata(take_rdata), .rd_shift(rd_shift), .req_rdata(req_rdata),
    .lad_out(lad_out), .lad_oe(lad_oe)
  );

  assign req_valid    = frame_n && (state_q == ST_REQ);
  assign req_write    = is_wr_q;
  assign req_locality = loc_field[LSEL_W-1:0];
  assign req_offset   = addr_q[OFS_W-1:0];
endmodule

// File: rtl/lpc_tpm_target_chk.sv
module lpc_tpm_target_chk #(
  parameter int LSEL_W   = 3,
  parameter int OFS_W    = 12,
  parameter int DATA_W   = 8,
  parameter int MAX_WAIT = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_n,
  input logic [3:0]        lad_out,
  input logic              lad_oe,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [LSEL_W-1:0] req_locality,
  input logic [OFS_W-1:0]  req_offset,
  input logic [DATA_W-1:0] req_wdata,
  input logic              req_grant
);
  localparam int WC_W = $clog2(MAX_WAIT + 2);
  logic [WC_W-1:0] wait_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_run <= '0;
    else if (lad_oe && lad_out == 4'b0110) begin
      if (wait_run != '1) wait_run <= wait_run + 1'b1;
    end else wait_run <= '0;
  end

  p_quiet_after_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (!lad_oe && !req_valid));

  p_sync_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_grant) |=> (lad_oe && lad_out == 4'b0000));

  p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_grant) |=> (!lad_oe && !req_valid));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!frame_n || (req_valid && $stable(req_write) &&
      $stable(req_locality) && $stable(req_offset) && $stable(req_wdata))));

  p_first_req_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !lad_oe);

  p_wait_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lad_oe) |-> (lad_out == 4'b0110));

  p_wait_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_run <= WC_W'(MAX_WAIT));
endmodule

bind lpc_tpm_target lpc_tpm_target_chk #(
  .LSEL_W(LSEL_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_out(lad_out),
  .lad_oe(lad_oe), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_locality(req_locality), .req_offset(req_offset),
  .req_wdata(req_wdata), .req_grant(req_grant)
);

// File: tb/tb_lpc_tpm_target.sv
`timescale 1ns/1ps
module tb_lpc_tpm_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_write;
  logic [2:0]  req_locality;
  logic [11:0] req_offset;
  logic [7:0]  req_wdata;
  logic        req_grant = 1'b0;
  logic [7:0]  req_rdata = 8'h00;

  int compared = 0;
  int mismatched = 0;

  // expected request fields for the cycle in flight
  bit          exp_wr;
  logic [2:0]  exp_loc;
  logic [11:0] exp_ofs;
  logic [7:0]  exp_wd;

  always #2.5 clk = ~clk;

  lpc_tpm_target dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_locality(req_locality),
    .req_offset(req_offset), .req_wdata(req_wdata), .req_grant(req_grant),
    .req_rdata(req_rdata)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // drive one bus clock and compare what the target shows during it
  task automatic step(input bit fr, input logic [3:0] lad, input bit rdy, input bit gnt,
                      input bit eoe, input logic [3:0] elad, input bit erv, input string req);
    bit bad;
    @(negedge clk);
    frame_n = fr; lad_in = lad; req_ready = rdy; req_grant = gnt;
    #1;
    bad = (lad_oe !== eoe) || (eoe && lad_out !== elad) || (req_valid !== erv) ||
          (erv && (req_write !== exp_wr || req_locality !== exp_loc ||
                   req_offset !== exp_ofs || (exp_wr && req_wdata !== exp_wd)));
    compared++;
    if (bad) begin
      mismatched++;
      $display("FAIL %s: oe=%0b lad=%h rv=%0b wr=%0b loc=%0d ofs=%h wd=%h | exp oe=%0b lad=%h rv=%0b wr=%0b loc=%0d ofs=%h wd=%h",
               req, lad_oe, lad_out, req_valid, req_write, req_locality, req_offset, req_wdata,
               eoe, elad, erv, exp_wr, exp_loc, exp_ofs, exp_wd);
    end
  endtask

  task automatic quiet(input string req);
    step(1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, req);
  endtask

  // host side up to the end of its turnaround; target must stay silent
  task automatic head(input logic [3:0] st, input logic [3:0] ct,
                      input logic [15:0] addr, input logic [7:0] wd, input string req);
    exp_wr = (ct == 4'b0010); exp_loc = addr[14:12]; exp_ofs = addr[11:0]; exp_wd = wd;
    step(1'b0, st, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, req);
    step(1'b1, ct, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, req);
    for (int i = 3; i >= 0; i--) step(1'b1, addr[4*i +: 4], 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, req);
    if (ct == 4'b0010) begin
      step(1'b1, wd[3:0], 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, req);
      step(1'b1, wd[7:4], 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, req);
    end
    quiet(req);
    quiet(req);
  endtask

  task automatic txn(input logic [3:0] st, input logic [3:0] ct, input logic [15:0] addr,
                     input logic [7:0] wd, input int waits, input bit gnt,
                     input logic [7:0] rd, input string req);
    bit ok;
    ok = (st == 4'b0101) && (ct == 4'b0000 || ct == 4'b0010) && (addr[15:12] < 4'd5);
    req_rdata = rd;
    head(st, ct, addr, wd, req);
    if (!ok) begin
      repeat (4) quiet({req, " ignored"});
      return;
    end
    for (int w = 0; w <= waits; w++)
      step(1'b1, 4'hF, (w == waits), gnt, (w > 0), 4'b0110, 1'b1, {req, " R5 R6 request"});
    if (!gnt) begin
      repeat (3) quiet({req, " R8 refused"});
      return;
    end
    step(1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, {req, " R7 sync"});
    if (!exp_wr) begin
      step(1'b1, 4'hF, 1'b0, 1'b0, 1'b1, rd[3:0], 1'b0, {req, " R9 data lo"});
      step(1'b1, 4'hF, 1'b0, 1'b0, 1'b1, rd[7:4], 1'b0, {req, " R9 data hi"});
    end
    quiet({req, " R9 release"});
    quiet({req, " R9 release"});
    quiet({req, " idle"});
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compared++;
    if (lad_oe !== 1'b0 || req_valid !== 1'b0) begin
      mismatched++;
      $display("FAIL R11 in reset: oe=%0b rv=%0b exp 0 0", lad_oe, req_valid);
    end
    rst_n = 1'b1;
    quiet("R11 after reset");
    quiet("R11 after reset");

    // R1 R9: reads, R4: writes
    txn(4'b0101, 4'b0000, 16'h0014, 8'h00, 0, 1'b1, 8'hA5, "R1 R9 read loc0");
    txn(4'b0101, 4'b0010, 16'h2F80, 8'h3C, 0, 1'b1, 8'h00, "R4 write loc2");
    txn(4'b0101, 4'b0000, 16'h4ABC, 8'h00, 3, 1'b1, 8'h7E, "R6 read loc4 stalled");
    txn(4'b0101, 4'b0010, 16'h1005, 8'h91, 2, 1'b1, 8'h00, "R6 write loc1 stalled");
    txn(4'b0101, 4'b0000, 16'h3FFF, 8'h00, 20, 1'b1, 8'hC3, "R6 long stall");

    // R8: refusals
    txn(4'b0101, 4'b0000, 16'h3024, 8'h00, 0, 1'b0, 8'h55, "R8 read refused");
    txn(4'b0101, 4'b0010, 16'h0018, 8'hEE, 2, 1'b0, 8'h00, "R8 write refused late");
    txn(4'b0101, 4'b0000, 16'h0F00, 8'h00, 0, 1'b1, 8'h69, "R8 next read ok");

    // R2: foreign cycles
    txn(4'b0000, 4'b0000, 16'h0060, 8'h00, 0, 1'b1, 8'h12, "R2 io read");
    txn(4'b0000, 4'b0010, 16'h0080, 8'h44, 0, 1'b1, 8'h12, "R2 io write");
    txn(4'b0101, 4'b0100, 16'h0014, 8'h00, 0, 1'b1, 8'h12, "R2 memory type");

    // R3: locality out of range
    txn(4'b0101, 4'b0000, 16'h5000, 8'h00, 0, 1'b1, 8'h12, "R3 locality 5");
    txn(4'b0101, 4'b0010, 16'hF123, 8'h77, 0, 1'b1, 8'h12, "R3 locality 15");

    // R10: strobe mid-address with non-start nibble
    step(1'b0, 4'b0101, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, "R10 abort addr");
    step(1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, "R10 abort addr");
    step(1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, "R10 abort addr");
    step(1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, "R10 abort addr");
    repeat (8) quiet("R10 stays idle");
    txn(4'b0101, 4'b0000, 16'h2010, 8'h00, 1, 1'b1, 8'h0F, "R10 after abort");

    // R10: restart with start nibble in the middle of write data
    step(1'b0, 4'b0101, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, "R10 restart");
    step(1'b1, 4'b0010, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, "R10 restart");
    for (int i = 0; i < 4; i++) step(1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, "R10 restart");
    step(1'b1, 4'h9, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, "R10 restart");
    txn(4'b0101, 4'b0000, 16'h1234, 8'h00, 0, 1'b1, 8'hB2, "R10 restarted read");

    // R10: strobe while the target stretches the cycle
    head(4'b0101, 4'b0000, 16'h0123, 8'h00, "R10 wait abort");
    step(1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, "R6 first request clock");
    step(1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 4'b0110, 1'b1, "R6 long wait");
    step(1'b0, 4'hF, 1'b0, 1'b0, 1'b1, 4'b0110, 1'b0, "R10 strobe during wait");
    step(1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, "R10 released after strobe");
    repeat (3) quiet("R10 released after strobe");
    txn(4'b0101, 4'b0010, 16'h4001, 8'h5A, 0, 1'b1, 8'h00, "R10 write after wait abort");

    finish_run();
  end
endmodule